// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is the host side of a four-wire serial link to an eight-input, 12-bit analog-to-digital converter. It pulls chip select low and generates the serial clock. It sends the command field, waits through the converter's sampling and null slots, and collects the twelve result bits. The block then deselects the converter and presents the result with a single-cycle completion pulse.

A request is one `start_i` pulse. At that moment the block latches `chan_i` (the input channel) and `single_i` (high for single-ended, low for differential). The serial clock half-period is `div_i` system clock cycles, with zero counted as one. Each frame has 19 serial clock pulses: start, mode, three channel bits, sample, null, and then twelve data slots. `busy_o` stays high from the accepted request until the minimum deselect time after the frame has elapsed. Requests that arrive in that window are dropped.

Top module: `sadc_reader`

## Requirements
- R1: After reset and whenever idle, `cs_n_o` is high, `sclk_o` is low, `mosi_o` is low, `busy_o` and `done_o` are low, and `result_o` is zero until the first completed frame.
- R2: A `start_i` seen while idle drives `cs_n_o` low with `sclk_o` low on the next clock edge, and `busy_o` is high in that same cycle. `cs_n_o` is low only while `busy_o` is high.
- R3: Every high phase and every low phase of `sclk_o` inside a frame lasts max(`div_i`,1) system cycles. A frame contains exactly 19 rising edges of `sclk_o`.
- R4: At the first five rising edges `mosi_o` carries, in this order: 1 (start), `single_i` (1 = single-ended, 0 = differential), then `chan_i[2]`, `chan_i[1]`, `chan_i[0]`. `mosi_o` changes only while `sclk_o` is low.
- R5: The values on `miso_i` at rising edges 6 (sample slot) and 7 (null bit, driven low by the converter) are not stored. The result comes only from rising edges 8 to 19.
- R6: The bit taken at rising edge 8 becomes `result_o[11]` and the one at edge 19 becomes `result_o[0]`, shifted in from the LSB side. `done_o` is high for exactly one cycle, and `result_o` changes only in that cycle and holds until the next one.
- R7: In the `done_o` cycle, `cs_n_o` is already high and `sclk_o` is low.
- R8: A `start_i` pulse while `busy_o` is high is ignored. No extra frame follows and the result is unchanged.
- R9: Between two frames `cs_n_o` stays high for at least two half-periods (one full serial clock period), even when `start_i` is held high continuously.
- R10: Changes on `chan_i` and `single_i` after a request is accepted have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| chan_i | input | CH_W (3) | Input channel number |
| div_i | input | DIV_W (8) | Serial clock half-period in system cycles (0 acts as 1) |
| miso_i | input | 1 | Converter data out |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Converter data in |
| busy_o | output | 1 | Frame or deselect time in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | RES_W (12) | Last conversion result |

## Verification
The properties assume `div_i` stays constant for the whole of a frame. They also assume `miso_i` changes only after falling serial clock edges, as the converter model drives it. The bench sets the divider between frames and never inside one. Its converter model changes `miso_i` half a system cycle after each falling edge it sees, and it drives ones during the command slots so that a misplaced capture shows up. The bench changes `chan_i`, `single_i` and `start_i` mid-frame only in the test that checks they are ignored.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Frame layout: start, mode and channel bits, then sample and null slots.
    localparam int CMD_EXTRA    = 2;  // start bit + mode bit on top of channel bits
    localparam int GAP_SLOTS    = 2;  // sample-and-hold slot + null bit slot
    localparam int GUARD_HALVES = 2;  // deselect time in half-periods

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FRAME = 2'd1,
        SEQ_GUARD = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sadc_tick_gen.sv
module sadc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (div_i == '0) ? '0 : div_i - 1'b1;
        tick_o   = run_i && (cnt_q >= last_cnt);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sadc_shift_in.sv
module sadc_shift_in #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clear_i) begin
            data_d = '0;
        end else if (shift_i) begin
            data_d = {data_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
    import sadc_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             single_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             miso_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    localparam int CMD_W     = CH_W + CMD_EXTRA;
    localparam int PRE_SLOTS = CMD_W + GAP_SLOTS;
    localparam int SLOTS     = PRE_SLOTS + RES_W;
    localparam int HALVES    = 2 * SLOTS;
    localparam int HW        = $clog2(HALVES + 1);

    localparam logic [HW-1:0] PRE_V   = HW'(PRE_SLOTS);
    localparam logic [HW-1:0] CMD_V   = HW'(CMD_W);
    localparam logic [HW-1:0] LAST_V  = HW'(HALVES - 1);
    localparam logic [HW-1:0] GUARD_V = HW'(GUARD_HALVES - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [HW-1:0]    half;
        logic             cs_n;
        logic             sclk;
        logic             mosi;
        logic [CMD_W-1:0] cmd;
        logic             done;
        logic [RES_W-1:0] res;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        st:   SEQ_IDLE,
        half: '0,
        cs_n: 1'b1,
        sclk: 1'b0,
        mosi: 1'b0,
        cmd:  '0,
        done: 1'b0,
        res:  '0
    };

    seq_regs_t r_d, r_q;

    logic             tick;
    logic             run;
    logic             shift_en;
    logic             clear_sh;
    logic [RES_W-1:0] sh_data;
    logic [HW-1:0]    slot;
    logic [HW-1:0]    nxt_slot;
    logic [CMD_W-1:0] cmd_sh;

    assign run = (r_q.st != SEQ_IDLE);

    sadc_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    sadc_shift_in #(
        .W (RES_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_sh),
        .shift_i (shift_en),
        .bit_i   (miso_i),
        .data_o  (sh_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shift_en = 1'b0;
        clear_sh = 1'b0;
        slot     = {1'b0, r_q.half[HW-1:1]};
        nxt_slot = slot + 1'b1;
        cmd_sh   = r_q.cmd << nxt_slot;

        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.st   = SEQ_FRAME;
                    r_d.half = '0;
                    r_d.cs_n = 1'b0;
                    r_d.sclk = 1'b0;
                    r_d.cmd  = {1'b1, single_i, chan_i};
                    r_d.mosi = 1'b1;
                    clear_sh = 1'b1;
                end
            end
            SEQ_FRAME: begin
                if (tick) begin
                    r_d.half = r_q.half + 1'b1;
                    if (!r_q.half[0]) begin
                        // low half ends: rising edge, converter output settled
                        r_d.sclk = 1'b1;
                        shift_en = (slot >= PRE_V);
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.half == LAST_V) begin
                            r_d.st   = SEQ_GUARD;
                            r_d.half = '0;
                            r_d.cs_n = 1'b1;
                            r_d.mosi = 1'b0;
                            r_d.done = 1'b1;
                            r_d.res  = sh_data;
                        end else begin
                            r_d.mosi = (nxt_slot < CMD_V) ? cmd_sh[CMD_W-1] : 1'b0;
                        end
                    end
                end
            end
            SEQ_GUARD: begin
                if (tick) begin
                    if (r_q.half == GUARD_V) begin
                        r_d.st   = SEQ_IDLE;
                        r_d.half = '0;
                    end else begin
                        r_d.half = r_q.half + 1'b1;
                    end
                end
            end
            default: begin
                r_d = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o   = r_q.cs_n;
    assign sclk_o   = r_q.sclk;
    assign mosi_o   = r_q.mosi;
    assign busy_o   = run;
    assign done_o   = r_q.done;
    assign result_o = r_q.res;

endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_o,
    input logic             sclk_o,
    input logic             mosi_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o && !mosi_o));

    p_select_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    p_mosi_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    p_done_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !sclk_o));

    p_select_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!busy_o));

    p_guard_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (busy_o && cs_n_o));

endmodule

bind sadc_reader sadc_reader_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sadc_reader_tb.sv
`timescale 1ns/1ps
module sadc_reader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        single_i = 1'b0;
    logic [2:0]  chan_i = 3'd0;
    logic [7:0]  div_i = 8'd1;
    logic        miso = 1'b1;
    logic        cs_n_o, sclk_o, mosi_o, busy_o, done_o;
    logic [11:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [11:0] salt = 12'h000;

    always #5 clk = ~clk;

    sadc_reader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .single_i (single_i),
        .chan_i   (chan_i),
        .div_i    (div_i),
        .miso_i   (miso),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic logic [11:0] conv_value(input logic mode, input logic [2:0] ch,
                                               input logic [11:0] s);
        logic [11:0] base;
        base = ({9'd0, ch} + 12'd1) * 12'd613;
        return base ^ (mode ? 12'hA5C : 12'h3C1) ^ s;
    endfunction

    // Converter model, evaluated between clock edges
    logic        m_prev_sclk = 1'b0;
    logic        m_prev_cs   = 1'b1;
    bit          m_started   = 0;
    int          m_rise      = 0;
    int          m_fall      = 0;
    logic [4:0]  m_cmd       = 5'd0;
    logic [11:0] m_val       = 12'd0;

    always @(negedge clk) begin
        if (!cs_n_o && m_prev_cs) begin
            m_started = 0;
            m_rise    = 0;
            m_fall    = 0;
            m_cmd     = 5'd0;
            miso      = 1'b1;
        end
        if (!cs_n_o) begin
            if (sclk_o && !m_prev_sclk) begin
                if (!m_started) begin
                    if (mosi_o) begin
                        m_started = 1;
                        m_rise    = 1;
                        m_cmd     = 5'd1;
                    end
                end else begin
                    m_rise++;
                    if (m_rise <= 5) m_cmd = {m_cmd[3:0], mosi_o};
                    if (m_rise == 5) m_val = conv_value(m_cmd[3], m_cmd[2:0], salt);
                end
            end else if (!sclk_o && m_prev_sclk && m_started) begin
                m_fall++;
                if (m_fall < 6)        miso = 1'b1;
                else if (m_fall == 6)  miso = 1'b0;   // null bit
                else if (m_fall <= 18) miso = m_val[18-m_fall];
                else                   miso = 1'b0;
            end
        end
        m_prev_sclk = sclk_o;
        m_prev_cs   = cs_n_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && busy_o; i++) @(negedge clk);
    endtask

    task automatic do_frame(input logic [2:0] ch, input logic sg, input logic [7:0] dv,
                            input bit disturb, input bit keep_start);
        int          eff;
        int          run;
        int          bad;
        int          cyc;
        int          hi;
        bit          seen;
        logic        prev;
        logic [11:0] exp;
        eff  = (dv == 0) ? 1 : int'(dv);
        salt = salt + 12'h1B7;
        exp  = conv_value(sg, ch, salt);
        chan_i   = ch;
        single_i = sg;
        div_i    = dv;
        start_i  = 1'b1;
        @(negedge clk);
        if (!keep_start) start_i = 1'b0;
        check(busy_o && !cs_n_o && !sclk_o, "R2 select on request", {busy_o, cs_n_o, sclk_o}, 3'b100);
        prev = 1'b0; run = 1; bad = 0; cyc = 0; seen = 0;
        while (!seen && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 25) begin
                start_i  = 1'b1;
                chan_i   = ~ch;
                single_i = ~sg;
            end
            if (disturb && cyc == 26) start_i = 1'b0;
            if (sclk_o != prev) begin
                if (run != eff) bad++;
                run  = 1;
                prev = sclk_o;
            end else begin
                run++;
            end
            if (done_o) seen = 1;
        end
        check(seen, "R6 done seen", seen, 1);
        check(result_o == exp, "R5 R6 result", result_o, exp);
        check(cs_n_o && !sclk_o, "R7 deselect at done", {cs_n_o, sclk_o}, 2'b10);
        check(m_cmd == {1'b1, sg, ch}, "R4 R10 command bits", m_cmd, {1'b1, sg, ch});
        check(m_rise == 19, "R3 clock count", m_rise, 19);
        check(bad == 0, "R3 half-period length", bad, 0);
        hi = 1;
        @(negedge clk);
        if (cs_n_o) hi++;
        check(!done_o, "R6 done width", done_o, 0);
        check(result_o == exp, "R6 result hold", result_o, exp);
        if (keep_start) begin
            for (int i = 0; i < 2000 && cs_n_o; i++) begin
                @(negedge clk);
                if (cs_n_o) hi++;
            end
            start_i = 1'b0;
            check(hi >= 2 * eff, "R9 deselect time", hi, 2 * eff);
            seen = 0;
            for (int i = 0; i < 4000 && !seen; i++) begin
                @(negedge clk);
                if (done_o) seen = 1;
            end
            check(seen && result_o == exp, "R9 back-to-back result", result_o, exp);
        end
        if (disturb) begin
            repeat (4 * eff + 10) @(negedge clk);
            check(cs_n_o && !busy_o, "R8 mid-frame start ignored", {cs_n_o, busy_o}, 2'b10);
            check(result_o == exp, "R8 result unchanged", result_o, exp);
        end
        wait_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n_o && !sclk_o && !mosi_o && !busy_o && !done_o && result_o == 0,
              "R1 reset state", {cs_n_o, sclk_o, mosi_o, busy_o, done_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n_o && !busy_o, "R1 idle after reset", {cs_n_o, busy_o}, 2'b10);

        for (int d = 1; d <= 3; d++) begin
            for (int m = 0; m < 2; m++) begin
                for (int c = 0; c < 8; c++) begin
                    do_frame(3'(c), 1'(m), 8'(d), 1'b0, 1'b0);
                end
            end
        end
        do_frame(3'd5, 1'b1, 8'd0, 1'b0, 1'b0);   // R3 divider zero acts as one
        do_frame(3'd6, 1'b0, 8'd2, 1'b1, 1'b0);   // R8 R10 disturbance
        do_frame(3'd1, 1'b1, 8'd3, 1'b0, 1'b1);   // R9 start held high
        do_frame(3'd2, 1'b0, 8'd1, 1'b0, 1'b1);   // R9 at fastest rate
        check(cs_n_o && !busy_o && !sclk_o, "R1 idle at end", {cs_n_o, busy_o, sclk_o}, 3'b100);

        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule